// File: doc/BRIEF.md
# Gated Channel Clock Divider Bank

This block derives several divided clocks from one parent PLL clock. Each channel divides the parent clock by an integer taken from its own control word and then by a fixed post-divider set per channel at build time. It produces a one-cycle enable pulse at the end of every divided period, a divided clock with a duty cycle close to 50%, and a status bit that shows whether the channel is running. All logic runs in the parent clock domain.

A channel runs only when three conditions hold: the parent PLL reports that it is running, the channel's own disable bit is clear, and the channel's hold bit is clear. The hold bits live in one register that all channels share, so a single write can stop or restart any group of channels at the same time.

A simple write port loads the shared hold register and the per-channel control words. A divider value of zero selects the largest divide the field can express. A new divider value is applied only at a period boundary, so a reprogrammed channel never produces a short pulse.

Top module: `pll_chan_divbank`

## Requirements
- R1: After reset, every channel is disabled and every hold bit is clear. All `tick`, `clk_div` and `running` outputs are low.
- R2: Address 0 is the shared hold register, and bit i of it holds channel i. Address 1+i is the control word of channel i. In that word, bits [7:0] are the divider and bit 8 is the disable bit.
- R3: A running channel has a period of N = D × P parent cycles, where D is the effective divider and P is the channel's post-divider. `tick` is high for one cycle, once per period.
- R4: A divider field of 0 is treated as 255.
- R5: In each period, `clk_div` is high for ceil(N/2) cycles. Those cycles start in the cycle after the `tick` cycle. When N = 1, `clk_div` stays high.
- R6: Setting the disable bit forces all three outputs of that channel low, starting with the second cycle after the write. They stay low with no pulses until the bit is cleared.
- R7: While `pll_run` is low, every channel's outputs are low, starting from the cycle after `pll_run` falls.
- R8: One write to the hold register gates or releases every channel whose bit is set or cleared by that write, in the same cycle. Channels whose bit is clear keep running with their period intact.
- R9: A divider written during a period takes effect from the next period. The current period completes with the old value. If the write lands on the last cycle of a period, the following period still uses the old value and the new value starts one period later.
- R10: When a channel starts, its counter begins at zero. `clk_div` goes high in the second cycle after the enabling write, and the first `tick` comes N cycles after the write.
- R11: `running` is high exactly while the channel's outputs are active. It follows the gating conditions one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent PLL clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_run | input | 1 | Parent PLL running indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| tick | output | NUM_CH | Per-channel end-of-period enable pulse |
| clk_div | output | NUM_CH | Per-channel divided clock |
| running | output | NUM_CH | Per-channel running status |

## Verification
The case most likely to break is a divider rewrite that lands in the same cycle as the channel's terminal count. In that cycle the period reload and the register write both occur on one clock edge. The bench provokes this by timing the write to the last cycle of a period it has already measured. It then expects one more tick at the old spacing, one full period at the old ratio, and only after that the new ratio. A second case, a gate-off write landing mid-period, is judged by requiring silence on all three outputs from the second cycle after the write and a counter restart from zero when the channel is enabled again.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  // Register map: shared gating register at the bottom, channel words above
  localparam int unsigned HOLD_ADDR = 0;
  localparam int unsigned CTRL_BASE = 1;

  function automatic int unsigned ctrl_addr(input int unsigned ch);
    return CTRL_BASE + ch;
  endfunction

  function automatic int unsigned post_or_one(input int unsigned p);
    return (p == 0) ? 1 : p;
  endfunction
endpackage

// File: rtl/pcd_regs.sv
module pcd_regs #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NUM_CH-1:0]             hold_o,
  output logic [NUM_CH-1:0]             dis_o,
  output logic [NUM_CH-1:0][DIV_W-1:0]  div_o
);
  import pcd_pkg::*;

  localparam int unsigned CTRL_W = DIV_W + 1;

  logic hold_sel;
  assign hold_sel = wr_en && (wr_addr == ADDR_W'(HOLD_ADDR));

  // Shared gating register: one write updates every channel's hold bit
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_o <= '0;
    end else if (hold_sel) begin
      hold_o <= wr_data[NUM_CH-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ctrl
    logic [CTRL_W-1:0] ctrl_q;
    logic              sel;

    assign sel = wr_en && (wr_addr == ADDR_W'(ctrl_addr(g)));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q <= {1'b1, {DIV_W{1'b0}}};
      end else if (sel) begin
        ctrl_q <= wr_data[CTRL_W-1:0];
      end
    end

    assign dis_o[g] = ctrl_q[DIV_W];
    assign div_o[g] = ctrl_q[DIV_W-1:0];
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;
endmodule

// File: rtl/pcd_channel.sv
module pcd_channel #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned POST_W = 3,
  parameter int unsigned POST   = 1,
  localparam int unsigned RW    = DIV_W + POST_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick_o,
  output logic             clk_o,
  output logic             running_o
);
  logic [DIV_W-1:0] div_eff;
  logic [RW-1:0]    ratio_cfg;
  logic [RW-1:0]    ratio_q;
  logic [RW-1:0]    ratio_cur;
  logic [RW-1:0]    cnt_q;
  logic [RW-1:0]    high_len;
  logic             wrap;

  always_comb begin
    // A zero field selects the largest divide the field can express
    div_eff   = (div_cfg == '0) ? {DIV_W{1'b1}} : div_cfg;
    ratio_cfg = RW'(div_eff) * RW'(POST);
    // The first running cycle takes the live setting; afterwards the latched one
    ratio_cur = running_o ? ratio_q : ratio_cfg;
    wrap      = (cnt_q == ratio_cur - RW'(1));
    high_len  = (ratio_cur + RW'(1)) >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      ratio_q   <= RW'(1);
      tick_o    <= 1'b0;
      clk_o     <= 1'b0;
      running_o <= 1'b0;
    end else if (!run_en) begin
      cnt_q     <= '0;
      ratio_q   <= ratio_cfg;
      tick_o    <= 1'b0;
      clk_o     <= 1'b0;
      running_o <= 1'b0;
    end else begin
      running_o <= 1'b1;
      tick_o    <= wrap;
      clk_o     <= (cnt_q < high_len);
      if (wrap) begin
        cnt_q   <= '0;
        ratio_q <= ratio_cfg;  // new divider only at a period boundary
      end else begin
        cnt_q   <= cnt_q + RW'(1);
        ratio_q <= ratio_cur;
      end
    end
  end
endmodule

// File: rtl/pll_chan_divbank.sv
module pll_chan_divbank #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned POST_W = 3,
  parameter logic [NUM_CH*POST_W-1:0] POST_DIVS = {3'd1, 3'd2, 3'd1},
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pll_run,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] tick,
  output logic [NUM_CH-1:0] clk_div,
  output logic [NUM_CH-1:0] running
);
  import pcd_pkg::*;

  logic [NUM_CH-1:0]            hold;
  logic [NUM_CH-1:0]            dis;
  logic [NUM_CH-1:0][DIV_W-1:0] div;
  logic [NUM_CH-1:0]            run_en;

  pcd_regs #(
    .NUM_CH (NUM_CH),
    .DIV_W  (DIV_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hold_o  (hold),
    .dis_o   (dis),
    .div_o   (div)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int unsigned PD = post_or_one(int'(POST_DIVS[g*POST_W +: POST_W]));

    assign run_en[g] = pll_run && !hold[g] && !dis[g];

    pcd_channel #(
      .DIV_W  (DIV_W),
      .POST_W (POST_W),
      .POST   (PD)
    ) u_ch (
      .clk       (clk),
      .rst       (rst),
      .run_en    (run_en[g]),
      .div_cfg   (div[g]),
      .tick_o    (tick[g]),
      .clk_o     (clk_div[g]),
      .running_o (running[g])
    );
  end
endmodule

// File: rtl/pll_chan_divbank_sva.sv
module pll_chan_divbank_sva #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              pll_run,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NUM_CH-1:0] tick,
  input logic [NUM_CH-1:0] clk_div,
  input logic [NUM_CH-1:0] running
);
  import pcd_pkg::*;

  // R7: parent stopped silences every channel on the next cycle
  a_r7_pll_stop: assert property (@(posedge clk) disable iff (rst)
    !pll_run |=> (running == '0 && clk_div == '0 && tick == '0));

  // R11: no output activity on a channel reported as not running
  a_r11_status_gate: assert property (@(posedge clk) disable iff (rst)
    ((~running & (clk_div | tick)) == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R8: a hold bit written high stops the channel two edges later
    a_r8_hold_gate: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(HOLD_ADDR) && wr_data[g]) |=> ##1 !running[g]);

    // R6: a disable bit written high stops the channel two edges later
    a_r6_disable_gate: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(ctrl_addr(g)) && wr_data[DIV_W]) |=> ##1 !running[g]);
  end

  logic unused_sva_bits;
  assign unused_sva_bits = ^wr_data;
endmodule

bind pll_chan_divbank pll_chan_divbank_sva #(
  .NUM_CH (NUM_CH),
  .DIV_W  (DIV_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_sva (
  .clk     (clk),
  .rst     (rst),
  .pll_run (pll_run),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .tick    (tick),
  .clk_div (clk_div),
  .running (running)
);

// File: tb/pll_chan_divbank_test.sv
module pll_chan_divbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;
  localparam int POST_W = 3;
  localparam logic [NUM_CH*POST_W-1:0] POSTS = {3'd1, 3'd2, 3'd1};
  localparam int WATCHDOG = 150000;

  logic clk = 0;
  logic rst = 1;
  logic pll_run = 1;
  logic wr_en = 0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [NUM_CH-1:0] tick, clk_div, running;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_chan_divbank #(.NUM_CH(NUM_CH), .POST_W(POST_W), .POST_DIVS(POSTS)) uut (
    .clk(clk), .rst(rst), .pll_run(pll_run), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .clk_div(clk_div), .running(running));

  function automatic int post_of(input int ch);
    int p = int'(POSTS[ch*POST_W +: POST_W]);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic int exp_ratio(input int ch, input int d);
    return ((d == 0) ? 255 : d) * post_of(ch);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_en = 1; wr_addr = 4'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_div(input int ch, input int d);
    wr(1 + ch, d);
    @(negedge clk);
  endtask

  task automatic wait_tick(input int ch, output bit ok);
    int n = 0;
    ok = 1;
    while (!tick[ch]) begin
      @(negedge clk);
      n++;
      if (n > 4000) begin ok = 0; break; end
    end
  endtask

  task automatic period_check(input int ch, input int n_exp, input string tag);
    bit ok;
    int len = 0, highs = 0;
    wait_tick(ch, ok);
    if (!ok) begin
      chk(0, {tag, " tick seen"}, 0, 1);
      return;
    end
    do begin
      @(negedge clk);
      len++;
      if (clk_div[ch]) highs++;
    end while (!tick[ch] && len < 4000);
    chk(len == n_exp, {tag, " period"}, len, n_exp);
    chk(highs == (n_exp + 1) / 2, {tag, " high cycles"}, highs, (n_exp + 1) / 2);
  endtask

  task automatic quiet_check(input logic [NUM_CH-1:0] mask, input int cycles, input string tag);
    int act = 0;
    for (int i = 0; i < cycles; i++) begin
      if (((tick | clk_div | running) & mask) != '0) act++;
      @(negedge clk);
    end
    chk(act == 0, tag, act, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", WATCHDOG);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state
    quiet_check('1, 10, "R1 reset outputs low");

    // R2 R3 R5: channel 0 divide by 4 via control word at address 1
    set_div(0, 4);
    period_check(0, 4, "R3 ch0 div4");
    chk(running[0] == 1'b1, "R11 running after enable", running[0], 1);

    // R3: post-divider of 2 on channel 1
    set_div(1, 3);
    period_check(1, 6, "R3 ch1 div3 post2");

    // R4: zero field means 255
    set_div(2, 0);
    period_check(2, 255, "R4 ch2 div0");

    // R5: N = 1 and odd N
    set_div(0, 1);
    period_check(0, 1, "R5 ch0 div1");
    set_div(0, 5);
    period_check(0, 5, "R5 ch0 div5 odd");

    // R6: disable bit (bit 8) silences the channel
    wr(1, 9'h105);
    @(negedge clk);
    quiet_check(3'b001, 20, "R6 disabled channel quiet");

    // R10: restart from zero
    begin
      int first = 0;
      bit hi1 = 0;
      wr(1, 7);
      for (int j = 1; j <= 10; j++) begin
        @(negedge clk);
        if (j == 1) hi1 = clk_div[0];
        if (tick[0] && first == 0) first = j;
      end
      chk(hi1 == 1'b1, "R10 clk_div high second cycle", hi1, 1);
      chk(first == 7, "R10 first tick after N", first, 7);
    end

    // R8: one hold write gates channels 0 and 2, channel 1 keeps running
    wr(0, 3'b101);
    @(negedge clk);
    chk(running == 3'b010, "R8 running pattern", running, 3'b010);
    quiet_check(3'b101, 20, "R8 held channels quiet");
    period_check(1, 6, "R8 unheld channel period");
    wr(0, 0);
    @(negedge clk);
    period_check(0, 7, "R8 release ch0");

    // R7: parent stopped
    pll_run = 0;
    @(negedge clk);
    quiet_check('1, 30, "R7 pll stopped quiet");
    pll_run = 1;
    period_check(1, 6, "R7 resume ch1");

    // R9: mid-period rewrite
    begin
      bit ok;
      int len = 1;
      wait_tick(0, ok);
      wr(1, 3);
      while (!tick[0] && len < 100) begin @(negedge clk); len++; end
      chk(len == 7, "R9 current period keeps old ratio", len, 7);
      period_check(0, 3, "R9 next period new ratio");
    end

    // R9: rewrite landing on the terminal-count cycle
    begin
      bit ok;
      wait_tick(0, ok);
      repeat (2) @(negedge clk);
      wr(1, 6);
      chk(tick[0] == 1'b1, "R9 tick on coinciding edge", tick[0], 1);
      period_check(0, 3, "R9 coincide old ratio once more");
      period_check(0, 6, "R9 coincide new ratio");
    end

    // R3: random dividers on random channels
    for (int it = 0; it < 12; it++) begin
      int ch = int'($urandom % 3);
      int d = int'($urandom % 16);
      set_div(ch, d);
      period_check(ch, exp_ratio(ch, d), "R3 random");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule